// File: doc/BRIEF.md
# VGA Framebuffer Scan-Out Engine

This block produces a 640x480, 60 Hz VGA raster at a 25 MHz pixel rate from a 100 MHz system clock. It uses a divide-by-four phase counter, so one pixel lasts four system clocks. It reads a linear framebuffer one byte at a time through a simple request/address port. An external SRAM scheduler answers that port. Each byte covers a group of 8 horizontal pixels. The byte for the next group is requested while the current group is on screen, so the display never waits for memory.

Each byte is unpacked in one of two ways. In monochrome mode every bit is one pixel, and a set bit lights red, green and blue together. In multicolor mode each channel has its own horizontal resolution. The four green bits each span two pixels. The two red bits and the two blue bits each span four pixels. Vertical resolution is the same in both modes. The colour outputs are forced low during blanking and whenever the enable input is low. Sync outputs are active low and are registered in step with the colour outputs.

Top module: `vga_fb_scanout`

## Requirements
- R1: While reset is active, and up to the first pixel tick, the colour outputs are 0, both syncs are 1 and no fetch is requested. Reset is released through a two-stage synchronizer. The first pixel is therefore visible after the 6th rising clock edge following the release. Each later pixel follows 4 clocks after the previous one.
- R2: A line is 800 pixels: 640 visible, 16 front porch, 96 sync, 48 back porch. The horizontal sync is low for pixels 656 to 751 of every line. Sync and colour of a pixel leave the block together on the same edge.
- R3: A frame is 525 lines: 480 visible, 10 front porch, 2 sync, 33 back porch. The vertical sync is low on lines 490 and 491. After reset the scan starts at pixel 0 of line 524, so the first visible line is fetched completely.
- R4: Monochrome mode (mode input 0): byte bit 7-i drives red, green and blue of pixel i of the group, where pixel 0 is leftmost.
- R5: Multicolor mode (mode input 1): green of pixel i is bit i/2 (bits 0..3), red is bit 4 + i/4, and blue is bit 6 + i/4.
- R6: The colour outputs are 0 outside the visible 640x480 area and whenever enable is low. A low enable does not stop fetches or sync generation.
- R7: A fetch request is a single-clock pulse in phase 0 of the first pixel of a group. It asks for the byte of the next visible group on the same line, or of group 0 of the next visible line when issued at pixel 792. Return data is captured at the end of the phase-2 clock of that pixel and is shown during the following group.
- R8: Fetch addresses run 0, 1, 2 ... up to 80*480-1 in raster order, one per request. The address returns to 0 before the first fetch of every frame. That gives 38,400 fetches per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 100 MHz system clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| mode_multi_i | input | 1 | 0 = monochrome unpacking, 1 = multicolor unpacking |
| enable_i | input | 1 | Screen enable; colour forced to 0 when low |
| fetch_req_o | output | 1 | One-clock request for a framebuffer byte |
| fetch_addr_o | output | ADDR_W (17) | Byte address of the requested framebuffer byte |
| fetch_data_i | input | 8 | Returned framebuffer byte |
| red_o | output | 1 | Red pixel output |
| green_o | output | 1 | Green pixel output |
| blue_o | output | 1 | Blue pixel output |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |

## Verification
Every pixel result, both syncs and colour, is registered on the pixel tick for the counter position it describes. It therefore appears exactly one pixel period, four clocks, after the counters reach that position. The first result appears on the 6th edge after reset release. The bench queues one expected item per pixel in scan order, starting at line 524. It pops one item on the falling edge after the 6th edge and then on every 4th falling edge. Fetch addresses are checked on the falling edge of the request clock. The bench returns data at that same point, so the data is stable well before the phase-2 capture edge. Mode and enable change only right after the first pixel of a frame, which lies inside vertical blanking.

// File: rtl/vga_scan_pkg.sv
package vga_scan_pkg;

  typedef enum logic {
    SCAN_MONO  = 1'b0,
    SCAN_MULTI = 1'b1
  } scan_mode_e;

  typedef struct packed {
    logic r;
    logic g;
    logic b;
  } rgb_t;

endpackage

// File: rtl/vga_scan_timing.sv
module vga_scan_timing #(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_TOT   = 800,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_TOT   = 525,
  parameter int CLK_DIV = 4,
  parameter int HW      = 10,
  parameter int VW      = 10,
  parameter int PW      = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic          pix_ce_o,
  output logic [PW-1:0] phase_o,
  output logic [HW-1:0] hcnt_o,
  output logic          act_o,
  output logic          line_vis_o,
  output logic          nxt_line_vis_o,
  output logic          frame_clr_o,
  output logic          hsync_n_o,
  output logic          vsync_n_o
);

  localparam logic [PW-1:0] PH_LAST = PW'(CLK_DIV - 1);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOT - 1);
  localparam logic [HW-1:0] H_VIS_L = HW'(H_VIS);
  localparam logic [HW-1:0] HS_BEG  = HW'(H_VIS + H_FP);
  localparam logic [HW-1:0] HS_END  = HW'(H_VIS + H_FP + H_SYNC);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOT - 1);
  localparam logic [VW-1:0] V_VIS_L = VW'(V_VIS);
  localparam logic [VW-1:0] V_VIS_M = VW'(V_VIS - 1);
  localparam logic [VW-1:0] VS_BEG  = VW'(V_VIS + V_FP);
  localparam logic [VW-1:0] VS_END  = VW'(V_VIS + V_FP + V_SYNC);

  logic [PW-1:0] ph_q, ph_d;
  logic [HW-1:0] h_q, h_d;
  logic [VW-1:0] v_q, v_d;
  logic          tick;

  assign tick = (ph_q == PH_LAST);

  always_comb begin
    ph_d = ph_q;
    h_d  = h_q;
    v_d  = v_q;
    if (tick) begin
      ph_d = '0;
      if (h_q == H_LAST) begin
        h_d = '0;
        v_d = (v_q == V_LAST) ? '0 : v_q + VW'(1);
      end else begin
        h_d = h_q + HW'(1);
      end
    end else begin
      ph_d = ph_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q <= '0;
      h_q  <= '0;
      v_q  <= V_LAST;
    end else begin
      ph_q <= ph_d;
      h_q  <= h_d;
      v_q  <= v_d;
    end
  end

  assign pix_ce_o       = tick;
  assign phase_o        = ph_q;
  assign hcnt_o         = h_q;
  assign line_vis_o     = (v_q < V_VIS_L);
  assign act_o          = (h_q < H_VIS_L) && (v_q < V_VIS_L);
  assign nxt_line_vis_o = (v_q == V_LAST) || (v_q < V_VIS_M);
  assign frame_clr_o    = (v_q == V_VIS_L);
  assign hsync_n_o      = !((h_q >= HS_BEG) && (h_q < HS_END));
  assign vsync_n_o      = !((v_q >= VS_BEG) && (v_q < VS_END));

  // R1
  ce_spacing_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_ce_o |=> !pix_ce_o);

endmodule

// File: rtl/vga_scan_fetch.sv
module vga_scan_fetch #(
  parameter int H_VIS  = 640,
  parameter int H_TOT  = 800,
  parameter int HW     = 10,
  parameter int PW     = 2,
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pix_ce_i,
  input  logic [PW-1:0]     phase_i,
  input  logic [HW-1:0]     hcnt_i,
  input  logic              line_vis_i,
  input  logic              nxt_line_vis_i,
  input  logic              frame_clr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] cur_o
);

  localparam int            GW       = $clog2(DATA_W);
  localparam logic [HW-1:0] LAST_REQ = HW'(H_VIS - DATA_W);
  localparam logic [HW-1:0] PRE_REQ  = HW'(H_TOT - DATA_W);
  localparam logic [PW-1:0] PH_REQ   = PW'(0);
  localparam logic [PW-1:0] PH_CAP   = PW'(2);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] nxt_q, nxt_d;
  logic [DATA_W-1:0] cur_q, cur_d;
  logic              grp_head, grp_tail, want;

  assign grp_head = (hcnt_i[GW-1:0] == '0);
  assign grp_tail = &hcnt_i[GW-1:0];
  assign want     = grp_head &&
                    ((line_vis_i && (hcnt_i < LAST_REQ)) ||
                     ((hcnt_i == PRE_REQ) && nxt_line_vis_i));
  assign req_o    = want && (phase_i == PH_REQ);

  always_comb begin
    addr_d = addr_q;
    if (frame_clr_i) begin
      addr_d = '0;
    end else if (req_o) begin
      addr_d = addr_q + ADDR_W'(1);
    end
    nxt_d = (want && (phase_i == PH_CAP)) ? data_i : nxt_q;
    cur_d = (pix_ce_i && grp_tail) ? nxt_q : cur_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      nxt_q  <= '0;
      cur_q  <= '0;
    end else begin
      addr_q <= addr_d;
      nxt_q  <= nxt_d;
      cur_q  <= cur_d;
    end
  end

  assign addr_o = addr_q;
  assign cur_o  = cur_q;

  // R7
  req_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |=> !req_o);

  // R8
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!req_o && !frame_clr_i) |=> $stable(addr_o));

endmodule

// File: rtl/vga_scan_unpack.sv
module vga_scan_unpack
  import vga_scan_pkg::*;
(
  input  logic [7:0]  byte_i,
  input  logic [2:0]  idx_i,
  input  scan_mode_e  mode_i,
  output rgb_t        pix_o
);

  logic mono_bit;

  assign mono_bit = byte_i[3'd7 - idx_i];

  always_comb begin
    case (mode_i)
      SCAN_MULTI: begin
        pix_o.g = byte_i[{1'b0, idx_i[2:1]}];
        pix_o.r = byte_i[{2'b10, idx_i[2]}];
        pix_o.b = byte_i[{2'b11, idx_i[2]}];
      end
      default: begin
        pix_o.r = mono_bit;
        pix_o.g = mono_bit;
        pix_o.b = mono_bit;
      end
    endcase
  end

endmodule

// File: rtl/vga_fb_scanout.sv
module vga_fb_scanout
  import vga_scan_pkg::*;
#(
  parameter int H_VIS   = 640,
  parameter int H_FP    = 16,
  parameter int H_SYNC  = 96,
  parameter int H_BP    = 48,
  parameter int V_VIS   = 480,
  parameter int V_FP    = 10,
  parameter int V_SYNC  = 2,
  parameter int V_BP    = 33,
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_multi_i,
  input  logic              enable_i,
  output logic              fetch_req_o,
  output logic [ADDR_W-1:0] fetch_addr_o,
  input  logic [7:0]        fetch_data_i,
  output logic              red_o,
  output logic              green_o,
  output logic              blue_o,
  output logic              hsync_o,
  output logic              vsync_o
);

  localparam int H_TOT = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOT = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW    = $clog2(H_TOT);
  localparam int VW    = $clog2(V_TOT);
  localparam int PW    = $clog2(CLK_DIV);

  logic [1:0]    sync_q;
  logic          rst_s;
  logic          pix_ce, act, line_vis, nxt_line_vis, frame_clr;
  logic          hs_n, vs_n;
  logic [PW-1:0] phase;
  logic [HW-1:0] hcnt;
  logic [7:0]    cur_byte;
  rgb_t          dec_pix;
  rgb_t          pix_q, pix_d;
  logic          hs_q, hs_d, vs_q, vs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end
  assign rst_s = sync_q[1];

  vga_scan_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_TOT(H_TOT),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_TOT(V_TOT),
    .CLK_DIV(CLK_DIV), .HW(HW), .VW(VW), .PW(PW)
  ) u_timing (
    .clk_i          (clk_i),
    .rst_ni         (rst_s),
    .pix_ce_o       (pix_ce),
    .phase_o        (phase),
    .hcnt_o         (hcnt),
    .act_o          (act),
    .line_vis_o     (line_vis),
    .nxt_line_vis_o (nxt_line_vis),
    .frame_clr_o    (frame_clr),
    .hsync_n_o      (hs_n),
    .vsync_n_o      (vs_n)
  );

  vga_scan_fetch #(
    .H_VIS(H_VIS), .H_TOT(H_TOT), .HW(HW), .PW(PW),
    .ADDR_W(ADDR_W), .DATA_W(8)
  ) u_fetch (
    .clk_i          (clk_i),
    .rst_ni         (rst_s),
    .pix_ce_i       (pix_ce),
    .phase_i        (phase),
    .hcnt_i         (hcnt),
    .line_vis_i     (line_vis),
    .nxt_line_vis_i (nxt_line_vis),
    .frame_clr_i    (frame_clr),
    .data_i         (fetch_data_i),
    .req_o          (fetch_req_o),
    .addr_o         (fetch_addr_o),
    .cur_o          (cur_byte)
  );

  vga_scan_unpack u_unpack (
    .byte_i (cur_byte),
    .idx_i  (hcnt[2:0]),
    .mode_i (scan_mode_e'(mode_multi_i)),
    .pix_o  (dec_pix)
  );

  always_comb begin
    pix_d = pix_q;
    hs_d  = hs_q;
    vs_d  = vs_q;
    if (pix_ce) begin
      pix_d = (act && enable_i) ? dec_pix : '0;
      hs_d  = hs_n;
      vs_d  = vs_n;
    end
  end

  always_ff @(posedge clk_i or negedge rst_s) begin
    if (!rst_s) begin
      pix_q <= '0;
      hs_q  <= 1'b1;
      vs_q  <= 1'b1;
    end else begin
      pix_q <= pix_d;
      hs_q  <= hs_d;
      vs_q  <= vs_d;
    end
  end

  assign red_o   = pix_q.r;
  assign green_o = pix_q.g;
  assign blue_o  = pix_q.b;
  assign hsync_o = hs_q;
  assign vsync_o = vs_q;

  // R6
  hsync_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    !hsync_o |-> ({red_o, green_o, blue_o} == 3'b000));

  // R6
  vsync_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    !vsync_o |-> ({red_o, green_o, blue_o} == 3'b000));

  // R7
  req_off_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_s)
    fetch_req_o |-> !pix_ce);

endmodule

// File: tb/test_vga_fb_scanout.sv
`timescale 1ns/1ps
module test_vga_fb_scanout;

  localparam int HV = 64, HF = 4, HS = 8, HB = 4;
  localparam int VV = 6,  VF = 1, VS = 2, VB = 1;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;
  localparam int AW = 17;
  localparam int BPL = HV / 8;
  localparam int FRB = BPL * VV;
  localparam int NFRAMES = 4;

  logic          clk;
  logic          rst_n;
  logic          mode_multi;
  logic          enable;
  logic          fetch_req;
  logic [AW-1:0] fetch_addr;
  logic [7:0]    fetch_data;
  logic          red, green, blue, hsync, vsync;

  int  vectors = 0;
  int  errors  = 0;
  bit  done    = 0;
  int  exp_addr = 0;
  int  n_fetch  = 0;
  logic [7:0] rd_q = 8'h00;

  typedef struct {
    bit    r, g, b, hs, vs, mode, en;
    string tag;
  } item_t;
  item_t scb[$];

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign fetch_data = rd_q;

  vga_fb_scanout #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB),
    .CLK_DIV(4), .ADDR_W(AW)
  ) i_vga_fb_scanout (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .mode_multi_i (mode_multi),
    .enable_i     (enable),
    .fetch_req_o  (fetch_req),
    .fetch_addr_o (fetch_addr),
    .fetch_data_i (fetch_data),
    .red_o        (red),
    .green_o      (green),
    .blue_o       (blue),
    .hsync_o      (hsync),
    .vsync_o      (vsync)
  );

  function automatic logic [7:0] mem_f(int a);
    return 8'((a * 29) ^ (a >> 3) ^ 8'hA5);
  endfunction

  task automatic check(bit ok, string tag, string what, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // driver: expected pixels of one frame in scan order, starting at line VT-1
  task automatic push_frame(bit mode, bit en);
    for (int k = 0; k < VT; k++) begin
      for (int x = 0; x < HT; x++) begin
        item_t      it;
        int         y;
        int         i;
        logic [7:0] d;
        y = (k == 0) ? VT - 1 : k - 1;
        it.mode = mode;
        it.en   = en;
        it.hs   = !((x >= HV + HF) && (x < HV + HF + HS));
        it.vs   = !((y >= VV + VF) && (y < VV + VF + VS));
        it.r = 1'b0; it.g = 1'b0; it.b = 1'b0;
        it.tag = "R6 blank";
        if (x < HV && y < VV) begin
          d = mem_f(y * BPL + x / 8);
          i = x % 8;
          if (!en) begin
            it.tag = "R6 disabled";
          end else if (!mode) begin
            it.r = d[7 - i]; it.g = d[7 - i]; it.b = d[7 - i];
            it.tag = "R4 R7 mono";
          end else begin
            it.g = d[i / 2];
            it.r = d[4 + i / 4];
            it.b = d[6 + i / 4];
            it.tag = "R5 R7 multi";
          end
        end
        scb.push_back(it);
      end
    end
  endtask

  // SRAM model: check the address, return the byte right away (R8)
  always @(negedge clk) begin
    if (rst_n && fetch_req) begin
      check(int'(fetch_addr) == exp_addr, "R8", "fetch address",
            int'(fetch_addr), exp_addr);
      rd_q = mem_f(int'(fetch_addr));
      exp_addr = (exp_addr + 1) % FRB;
      n_fetch++;
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  // monitor
  initial begin
    item_t it;
    mode_multi = 1'b0;
    enable     = 1'b1;
    rst_n      = 1'b1;
    #1 rst_n = 1'b0;
    push_frame(1'b0, 1'b1);
    push_frame(1'b1, 1'b1);
    push_frame(1'b1, 1'b0);
    push_frame(1'b0, 1'b1);
    repeat (3) @(negedge clk);
    check({red, green, blue} == 3'b000, "R1", "rgb in reset", {red, green, blue}, 0);
    check({hsync, vsync} == 2'b11, "R1", "syncs in reset", {hsync, vsync}, 3);
    rst_n = 1'b1;
    @(negedge clk);
    check(fetch_req == 1'b0, "R1", "request after release", fetch_req, 0);
    repeat (4) @(negedge clk);
    check({red, green, blue, hsync, vsync} == 5'b00011, "R1", "idle before first tick",
          {red, green, blue, hsync, vsync}, 3);
    @(negedge clk);
    while (scb.size() > 0) begin
      it = scb.pop_front();
      check({red, green, blue} == {it.r, it.g, it.b}, it.tag, "rgb",
            {red, green, blue}, {it.r, it.g, it.b});
      check(hsync == it.hs, "R2", "hsync", hsync, it.hs);
      check(vsync == it.vs, "R3", "vsync", vsync, it.vs);
      mode_multi = it.mode;
      enable     = it.en;
      if (scb.size() > 0) repeat (4) @(negedge clk);
    end
    check(n_fetch == NFRAMES * FRB, "R8", "fetches per run", n_fetch, NFRAMES * FRB);
    finish_run();
  end

endmodule